// File: doc/BRIEF.md
# Low-Side Inverter Trip Sequencer

This block is the digital protection core for the three low-side switches of a three-phase inverter leg set. It takes the three active-high low-side PWM commands, an over-current comparator flag and a supply undervoltage flag, and produces three gate-enable outputs, a soft-discharge request for the gate drivers and an active-low fault line for an open-drain pad. Comparators, shunt, RC network and the gate buffers themselves live outside the block. Every time constant is counted in clock cycles and set by a parameter.

A flag must persist through its own persistence filter before it acts. A qualified over-current trip blanks all three gates at once through the soft-discharge path. After a short delay it pulls the fault line low and holds it for a minimum window. A qualified undervoltage blanks the gates and holds the fault line for as long as the supply stays low, with no fixed length. When all protection has ended, each phase stays dark until its own input shows a fresh low-to-high transition. Reset leaves every phase disarmed in the same way.

Top module: `lowside_trip_seq`

## Requirements
- R1: The over-current flag trips protection only after it has been sampled high on OC_FILT consecutive clock edges; a pulse of OC_FILT-1 samples leaves gates, soft_off and fault_n unchanged.
- R2: One cycle after the over-current filter qualifies, all three gate_en bits are 0 together, whichever phases were on.
- R3: While protection holds the gates off, soft_off is 1; soft_off is 1 only when every gate_en bit is 0, and it returns to 0 in the cycle protection ends.
- R4: After an over-current trip, fault_n goes low exactly FO_DELAY cycles after the gates go off.
- R5: An over-current fault keeps fault_n low for at least FO_MIN cycles; if no flag is still active, fault_n returns high after exactly FO_MIN cycles.
- R6: While a fault is active, a high PWM input, including one that rises during the fault, does not turn its gate on.
- R7: After protection ends, a phase turns on only after a new low-to-high transition of its input; an input that stayed high gives gate_en 0 for that phase.
- R8: The undervoltage flag acts only after UV_FILT consecutive high samples; it then turns all gates off, sets soft_off and drives fault_n low in the same cycle, and releases them two cycles after the flag returns low.
- R9: When over-current and undervoltage overlap, or the over-current flag outlasts the minimum window, fault_n is released only once both flags have ended and the minimum window has expired.
- R10: During and after synchronous reset the gates are off, soft_off is 0 and fault_n is 1; an input that is already high when reset ends does not turn its gate on.
- R11: In normal operation each gate_en bit follows its own PWM input one clock later, independently of the other phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_lo | input | NPH | Low-side PWM commands, active high, one bit per phase |
| oc_flag | input | 1 | Over-current comparator output, active high |
| uv_flag | input | 1 | Supply undervoltage flag, active high |
| gate_en | output | NPH | Registered gate enables, one bit per phase |
| soft_off | output | 1 | Registered request for slow gate discharge during protection |
| fault_n | output | 1 | Registered fault indication, active low, for an open-drain pad |

## Verification
The assertions take the three commands and both flags to be already synchronous to clk, so that each is sampled once per edge and a filter length is a count of edges. They also take every time parameter to be at least one. The stimulus therefore changes inputs only on the falling clock edge and holds each level for whole cycles. Glitch cases are built from exact sample counts one short of the filter length, and the overlap cases place the undervoltage window so that it starts inside and ends after the minimum fault window.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  // Protection sequencer states
  typedef enum logic [2:0] {
    TS_RUN    = 3'd0,  // normal operation
    TS_OCDLY  = 3'd1,  // over-current trip, fault line not yet asserted
    TS_OCMIN  = 3'd2,  // minimum fault window running
    TS_OCWAIT = 3'd3,  // window expired, waiting for flags to clear
    TS_UV     = 3'd4   // undervoltage hold
  } trip_state_t;

endpackage

// File: rtl/lsp_persist_filter.sv
module lsp_persist_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);

  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_cnt;

  // q rises on the edge of the LEN-th consecutive high sample, falls at once
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      q       <= 1'b0;
    end else if (!din) begin
      run_cnt <= '0;
      q       <= 1'b0;
    end else if (run_cnt == LAST) begin
      q       <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R1 / R8: a qualified flag implies the raw flag was high on the prior sample
  a_r1_qualified_had_input: assert property (@(posedge clk) disable iff (rst)
    q |-> $past(din));

endmodule

// File: rtl/lsp_trip_fsm.sv
module lsp_trip_fsm
  import lsp_pkg::*;
#(
  parameter int unsigned FO_DELAY = 3,
  parameter int unsigned FO_MIN   = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_q,
  input  logic uv_q,
  output logic block,
  output logic soft_off_q,
  output logic fault_n_q
);

  localparam int unsigned MAXC = (FO_DELAY > FO_MIN) ? FO_DELAY : FO_MIN;
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(FO_DELAY - 1);
  localparam logic [CW-1:0] MIN_LAST = CW'(FO_MIN - 1);

  trip_state_t   state, nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          fault_act;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      TS_RUN: begin
        if (oc_q) begin
          nxt     = TS_OCDLY;
          cnt_nxt = '0;
        end else if (uv_q) begin
          nxt = TS_UV;
        end
      end
      TS_OCDLY: begin
        if (cnt == DLY_LAST) begin
          nxt     = TS_OCMIN;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      TS_OCMIN: begin
        if (cnt == MIN_LAST) begin
          nxt     = (oc_q || uv_q) ? TS_OCWAIT : TS_RUN;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      TS_OCWAIT: begin
        if (!oc_q && !uv_q) nxt = TS_RUN;
      end
      TS_UV: begin
        if (oc_q) begin
          nxt     = TS_OCDLY;
          cnt_nxt = '0;
        end else if (!uv_q) begin
          nxt = TS_RUN;
        end
      end
      default: nxt = TS_RUN;
    endcase
  end

  assign block = (nxt != TS_RUN);

  always_comb begin
    fault_act = (nxt == TS_OCMIN) || (nxt == TS_OCWAIT) || (nxt == TS_UV) ||
                ((nxt == TS_OCDLY) && uv_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TS_RUN;
      cnt        <= '0;
      soft_off_q <= 1'b0;
      fault_n_q  <= 1'b1;
    end else begin
      state      <= nxt;
      cnt        <= cnt_nxt;
      soft_off_q <= block;
      fault_n_q  <= !fault_act;
    end
  end

  // Checker state: length of the current low period of the fault line
  localparam int unsigned LW = (FO_MIN < 2) ? 1 : $clog2(FO_MIN + 1);
  logic [LW-1:0] lo_len;
  logic          oc_cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_len   <= '0;
      oc_cause <= 1'b0;
    end else begin
      if (fault_n_q)                    lo_len <= '0;
      else if (lo_len != LW'(FO_MIN))   lo_len <= lo_len + 1'b1;
      if (state == TS_OCMIN)            oc_cause <= 1'b1;
      else if (fault_n_q)               oc_cause <= 1'b0;
    end
  end

  // R2: a qualified over-current flag blocks the gates on the next edge
  a_r2_oc_blocks: assert property (@(posedge clk) disable iff (rst)
    oc_q |=> soft_off_q);

  // R8: a qualified undervoltage flag drives the fault line low on the next edge
  a_r8_uv_faults: assert property (@(posedge clk) disable iff (rst)
    uv_q |=> !fault_n_q);

  // R5: an over-current fault line stays low for at least FO_MIN cycles
  a_r5_min_window: assert property (@(posedge clk) disable iff (rst)
    ($rose(fault_n_q) && oc_cause) |-> (lo_len >= LW'(FO_MIN)));

  // R4: the fault line falls only while the gates are already blocked
  a_r4_fault_after_block: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n_q) |-> soft_off_q);

endmodule

// File: rtl/lsp_phase_gate.sv
module lsp_phase_gate (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  input  logic block,
  output logic gate_q
);

  logic pwm_d;
  logic armed;
  logic rise;
  logic arm_nxt;

  assign rise = pwm_in & ~pwm_d;

  // Re-arm bit: cleared by any protection, set by a fresh rising edge
  always_comb begin
    if (block) arm_nxt = 1'b0;
    else       arm_nxt = armed | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_d  <= 1'b1;  // a level already high at reset is not an edge
      armed  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      pwm_d  <= pwm_in;
      armed  <= arm_nxt;
      gate_q <= arm_nxt & pwm_in;
    end
  end

  // R11: a low command turns the gate off on the next edge
  a_r11_low_cmd_off: assert property (@(posedge clk) disable iff (rst)
    !pwm_in |=> !gate_q);

  // R6: a gate never turns on from a cycle in which protection was blocking
  a_r6_no_on_when_blocked: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> (!$past(block) && $past(pwm_in)));

endmodule

// File: rtl/lowside_trip_seq.sv
module lowside_trip_seq #(
  parameter int unsigned NPH      = 3,
  parameter int unsigned OC_FILT  = 50,
  parameter int unsigned UV_FILT  = 1875,
  parameter int unsigned FO_DELAY = 313,
  parameter int unsigned FO_MIN   = 3750000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] pwm_lo,
  input  logic           oc_flag,
  input  logic           uv_flag,
  output logic [NPH-1:0] gate_en,
  output logic           soft_off,
  output logic           fault_n
);

  logic oc_q;
  logic uv_q;
  logic block;

  lsp_persist_filter #(.LEN(OC_FILT)) u_oc_filt (
    .clk (clk),
    .rst (rst),
    .din (oc_flag),
    .q   (oc_q)
  );

  lsp_persist_filter #(.LEN(UV_FILT)) u_uv_filt (
    .clk (clk),
    .rst (rst),
    .din (uv_flag),
    .q   (uv_q)
  );

  lsp_trip_fsm #(.FO_DELAY(FO_DELAY), .FO_MIN(FO_MIN)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .oc_q       (oc_q),
    .uv_q       (uv_q),
    .block      (block),
    .soft_off_q (soft_off),
    .fault_n_q  (fault_n)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    lsp_phase_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .pwm_in (pwm_lo[p]),
      .block  (block),
      .gate_q (gate_en[p])
    );
  end

  // R3: the soft-discharge request never coexists with an enabled gate
  a_r3_soft_gates_off: assert property (@(posedge clk) disable iff (rst)
    soft_off |-> (gate_en == '0));

  // R6: an active fault line never coexists with an enabled gate
  a_r6_fault_gates_off: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (gate_en == '0));

  // R10: reset leaves gates off and the fault line released
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (gate_en == '0 && !soft_off && fault_n));

endmodule

// File: tb/lowside_trip_seq_tb_top.sv
module lowside_trip_seq_tb_top;

  localparam int NPH  = 3;
  localparam int OCF  = 4;
  localparam int UVF  = 10;
  localparam int DLY  = 3;
  localparam int MINW = 40;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NPH-1:0] pwm_lo = '1;
  logic           oc_flag = 1'b0;
  logic           uv_flag = 1'b0;
  logic [NPH-1:0] gate_en;
  logic           soft_off;
  logic           fault_n;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int             at;
    logic [NPH-1:0] g;
    logic           s;
    logic           f;
    string          tag;
  } exp_t;

  exp_t sb[$];

  lowside_trip_seq #(
    .NPH(NPH), .OC_FILT(OCF), .UV_FILT(UVF), .FO_DELAY(DLY), .FO_MIN(MINW)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .pwm_lo   (pwm_lo),
    .oc_flag  (oc_flag),
    .uv_flag  (uv_flag),
    .gate_en  (gate_en),
    .soft_off (soft_off),
    .fault_n  (fault_n)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: schedule an expected output triple for an absolute cycle
  task automatic expect_at(input int at, input logic [NPH-1:0] g, input logic s,
                           input logic f, input string tag);
    sb.push_back('{at, g, s, f, tag});
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: compare outputs between edges against due scoreboard items
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        n_vec++;
        if (gate_en !== sb[i].g || soft_off !== sb[i].s || fault_n !== sb[i].f) begin
          n_bad++;
          $display("FAIL %s @%0d: gate=%b soft=%b fault_n=%b expected gate=%b soft=%b fault_n=%b",
                   sb[i].tag, cyc, gate_en, soft_off, fault_n, sb[i].g, sb[i].s, sb[i].f);
        end
        sb.delete(i);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int c;
    @(negedge clk);
    // R10: reset state, inputs already high
    expect_at(cyc + 1, 3'b000, 1'b0, 1'b1, "R10 in reset");
    wait_to(cyc + 4);
    rst = 1'b0;
    c = cyc;
    expect_at(c + 1, 3'b000, 1'b0, 1'b1, "R10 high level at reset release");
    expect_at(c + 4, 3'b000, 1'b0, 1'b1, "R10 no edge no gate");
    wait_to(c + 6);

    // R11: normal following, per phase
    pwm_lo = 3'b000; c = cyc;
    wait_to(c + 1); pwm_lo = 3'b101;
    expect_at(c + 2, 3'b101, 1'b0, 1'b1, "R11 pattern 101");
    wait_to(c + 2); pwm_lo = 3'b111;
    expect_at(c + 3, 3'b111, 1'b0, 1'b1, "R11 pattern 111");
    wait_to(c + 3); pwm_lo = 3'b010;
    expect_at(c + 4, 3'b010, 1'b0, 1'b1, "R11 pattern 010");
    wait_to(c + 4); pwm_lo = 3'b111;
    expect_at(c + 5, 3'b111, 1'b0, 1'b1, "R11 back to 111");
    wait_to(c + 8);

    // R1: over-current pulse one sample short of the filter
    oc_flag = 1'b1; c = cyc;
    wait_to(c + OCF - 1); oc_flag = 1'b0;
    expect_at(c + OCF + 3, 3'b111, 1'b0, 1'b1, "R1 short pulse ignored");
    wait_to(c + OCF + 8);

    // R2..R7: over-current trip with all phases on
    oc_flag = 1'b1; c = cyc;
    expect_at(c + OCF,     3'b111, 1'b0, 1'b1, "R2 just before trip");
    expect_at(c + OCF + 1, 3'b000, 1'b1, 1'b1, "R2 R3 all gates off with soft_off");
    expect_at(c + OCF + DLY,     3'b000, 1'b1, 1'b1, "R4 fault not yet");
    expect_at(c + OCF + DLY + 1, 3'b000, 1'b1, 1'b0, "R4 fault asserted");
    wait_to(c + OCF + 3); oc_flag = 1'b0;
    wait_to(c + 20); pwm_lo = 3'b000;
    wait_to(c + 22); pwm_lo = 3'b111;
    expect_at(c + 23, 3'b000, 1'b1, 1'b0, "R6 rising input during fault");
    expect_at(c + OCF + DLY + MINW,     3'b000, 1'b1, 1'b0, "R5 last window cycle");
    expect_at(c + OCF + DLY + MINW + 1, 3'b000, 1'b0, 1'b1, "R5 R3 release after window");
    expect_at(c + OCF + DLY + MINW + 5, 3'b000, 1'b0, 1'b1, "R7 held level no gate");
    wait_to(c + 55); pwm_lo = 3'b000;
    wait_to(c + 56); pwm_lo = 3'b111;
    expect_at(c + 57, 3'b111, 1'b0, 1'b1, "R7 fresh edge re-arms");
    wait_to(c + 62);

    // R8: undervoltage pulse one sample short of the filter
    uv_flag = 1'b1; c = cyc;
    wait_to(c + UVF - 1); uv_flag = 1'b0;
    expect_at(c + UVF + 2, 3'b111, 1'b0, 1'b1, "R8 short undervoltage ignored");
    wait_to(c + UVF + 6);

    // R8: qualified undervoltage, then recovery
    uv_flag = 1'b1; c = cyc;
    expect_at(c + UVF,     3'b111, 1'b0, 1'b1, "R8 before qualification");
    expect_at(c + UVF + 1, 3'b000, 1'b1, 1'b0, "R8 blocked and fault");
    wait_to(c + 30); uv_flag = 1'b0;
    expect_at(c + 31, 3'b000, 1'b1, 1'b0, "R8 still held");
    expect_at(c + 32, 3'b000, 1'b0, 1'b1, "R8 released");
    expect_at(c + 34, 3'b000, 1'b0, 1'b1, "R7 after undervoltage no edge");
    wait_to(c + 36); pwm_lo = 3'b000;
    wait_to(c + 37); pwm_lo = 3'b111;
    expect_at(c + 38, 3'b111, 1'b0, 1'b1, "R7 edge after undervoltage");
    wait_to(c + 42);

    // R9: undervoltage outlasting the minimum window
    oc_flag = 1'b1; c = cyc;
    wait_to(c + 5); uv_flag = 1'b1;
    wait_to(c + 7); oc_flag = 1'b0;
    expect_at(c + OCF + DLY + MINW + 1, 3'b000, 1'b1, 1'b0, "R9 window done, undervoltage holds");
    wait_to(c + 60); uv_flag = 1'b0;
    expect_at(c + 61, 3'b000, 1'b1, 1'b0, "R9 undervoltage just ended");
    expect_at(c + 62, 3'b000, 0, 1'b1, "R9 both clear release");
    wait_to(c + 66);

    // R9: over-current flag outlasting the minimum window
    oc_flag = 1'b1; c = cyc;
    expect_at(c + 60, 3'b000, 1'b1, 1'b0, "R9 flag persists past window");
    wait_to(c + 70); oc_flag = 1'b0;
    expect_at(c + 71, 3'b000, 1'b1, 1'b0, "R9 flag just ended");
    expect_at(c + 72, 3'b000, 1'b0, 1'b1, "R9 release after flag ends");
    wait_to(c + 76);

    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL scoreboard: %0d items never compared, expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule